// File: doc/BRIEF.md
# Cascadable Recirculating Serial Shift Register

This block is a delay line built from a parameterised number of 64-stage serial segments. Segment 0 is the leftmost and takes the serial input. Each later segment is fed from the last stage of the segment to its left. The bit entering the line is chosen by one of two rules:

- a select line picks one of two external serial inputs, or
- a recirculate control feeds back the bit that was at the far end of the chain when the shift began.

The far end is presented in true and complemented form. Every segment's last stage is also brought out as a tap.

A chain shift is started by a one-cycle request. Two orderings are offered.

- **Simultaneous:** every segment's shift strobe is raised together for one cycle.
- **Staggered:** a one-hot strobe starts at the rightmost segment and moves one segment left per cycle. Each segment therefore shifts only after its right-hand neighbour has already moved its last bit along.

The strobes are brought out as the per-segment clock-out indication. A done pulse follows the cycle in which the leftmost segment shifted. A holding register keeps the recirculated bit from the start of a sequence until the leftmost segment consumes it.

Top module: `cascade_shift_chain`

## Requirements
- R1: A synchronous active-high reset clears every stage, the holding register, all strobes and the done pulse.
- R2: While a segment's strobe is high at a clock edge, that segment shifts: stage 0 takes its serial input and stage k takes stage k-1. Segment 0's serial input is the chain input. Segment g>0 takes stage 63 of segment g-1.
- R3: With recirculation off, the chain input is din_a when sel_b is 0 and din_b when sel_b is 1. It is sampled in the cycle where strobe bit 0 is high.
- R4: tail_q is stage 63 of the rightmost segment and tail_qn is its complement. seg_tap[g] is stage 63 of segment g.
- R5: In simultaneous mode (stagger=0 at the accepting edge), all seg_strobe bits are high during the one cycle after acceptance. They are all low afterwards, and done is high in the following cycle only.
- R6: In staggered mode (stagger=1 at the accepting edge), seg_strobe is one-hot. It equals bit SEGS-1 in the first cycle after acceptance and moves to the next lower index each cycle. done is high in the cycle after bit 0 was set.
- R7: With recirc high, the chain input is the tail bit captured at the accepting edge. In both modes one chain shift then rotates the whole SEGS*64-bit line by one position.
- R8: While no strobe is high, no stage changes, whatever the data, select and mode inputs do.
- R9: A request is accepted only while no strobe is high. A request held during a sequence starts no second shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_req | input | 1 | Request one chain shift |
| stagger | input | 1 | 1 = staggered right-to-left ordering, 0 = simultaneous |
| recirc | input | 1 | 1 = feed back the chain's last bit, 0 = take external data |
| sel_b | input | 1 | External source select: 0 = din_a, 1 = din_b |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| seg_strobe | output | SEGS | Per-segment shift strobe (clock-out indication) |
| seg_tap | output | SEGS | Stage 63 of each segment |
| tail_q | output | 1 | Last stage of the rightmost segment |
| tail_qn | output | 1 | Complement of tail_q |
| done | output | 1 | One-cycle pulse after the leftmost segment shifted |

## Verification
The hardest case to reach is recirculation in staggered mode. There the rightmost segment has already overwritten the tail before segment 0 shifts, so only the holding register can supply the right bit. The bench reaches this case by first loading a line with a known pattern. It then issues random recirculating staggered shifts, some of them with the request held high for the whole sequence, and compares every tap against a rotated reference vector. The strobe walk is checked cycle by cycle during those same sequences.

// File: rtl/cascade_shift_chain.sv
module cascade_shift_chain #(
  parameter int SEGS   = 4,
  parameter int STAGES = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_req,
  input  logic            stagger,
  input  logic            recirc,
  input  logic            sel_b,
  input  logic            din_a,
  input  logic            din_b,
  output logic [SEGS-1:0] seg_strobe,
  output logic [SEGS-1:0] seg_tap,
  output logic            tail_q,
  output logic            tail_qn,
  output logic            done
);
  localparam logic [SEGS-1:0] RIGHT_ONE = SEGS'(1) << (SEGS - 1);
  localparam logic [SEGS-1:0] ALL_ONES  = {SEGS{1'b1}};

  logic [STAGES-1:0] seg [SEGS];
  logic [SEGS-1:0]   seg_in;
  logic [SEGS-1:0]   strb;
  logic              hold;
  logic              busy, accept, feed;

  assign busy   = |strb;
  assign accept = shift_req && !busy;
  assign feed   = recirc ? hold : (sel_b ? din_b : din_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= '0;
      hold <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strb[0];
      if (accept) begin
        strb <= stagger ? RIGHT_ONE : ALL_ONES;
        hold <= tail_q;
      end else if (strb[0]) begin
        strb <= '0;
      end else begin
        strb <= strb >> 1;
      end
    end
  end

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    if (g == 0) begin : g_head
      assign seg_in[g] = feed;
    end else begin : g_link
      assign seg_in[g] = seg[g-1][STAGES-1];
    end

    always_ff @(posedge clk) begin
      if (rst)          seg[g] <= '0;
      else if (strb[g]) seg[g] <= {seg[g][STAGES-2:0], seg_in[g]};
    end

    assign seg_tap[g] = seg[g][STAGES-1];
  end

  assign seg_strobe = strb;
  assign tail_q     = seg_tap[SEGS-1];
  assign tail_qn    = ~tail_q;

  p_strobe_shape_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb) || (strb == ALL_ONES));

  p_strobe_walk_r6: assert property (@(posedge clk) disable iff (rst)
    ($onehot(strb) && !strb[0]) |=> (strb == ($past(strb) >> 1)));

  p_done_follows_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(strb[0]));

  p_hold_kept_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold));

  p_idle_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(seg_tap));

  p_entry_bit_r2: assert property (@(posedge clk) disable iff (rst)
    strb[0] |=> (seg[0][0] == $past(feed)));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !strb[0]) |=> (strb != ALL_ONES) || $past(strb == ALL_ONES));
endmodule

// File: tb/sim_cascade_shift_chain.sv
module sim_cascade_shift_chain;
  localparam int SEGS   = 4;
  localparam int STAGES = 64;
  localparam int TOTAL  = SEGS * STAGES;

  logic clk = 1'b0;
  logic rst, shift_req, stagger, recirc, sel_b, din_a, din_b;
  logic [SEGS-1:0] seg_strobe, seg_tap;
  logic tail_q, tail_qn, done;

  int checks = 0;
  int errors = 0;
  logic [TOTAL-1:0] model;

  always #4 clk = ~clk;

  cascade_shift_chain #(.SEGS(SEGS), .STAGES(STAGES)) u0 (
    .clk, .rst, .shift_req, .stagger, .recirc, .sel_b, .din_a, .din_b,
    .seg_strobe, .seg_tap, .tail_q, .tail_qn, .done);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [SEGS-1:0] exp_taps(input logic [TOTAL-1:0] m);
    logic [SEGS-1:0] t;
    for (int g = 0; g < SEGS; g++) t[g] = m[g*STAGES + STAGES-1];
    return t;
  endfunction

  function automatic logic next_bit(input logic rc, input logic sb, input logic a, input logic b,
                                    input logic [TOTAL-1:0] m);
    return rc ? m[TOTAL-1] : (sb ? b : a);
  endfunction

  task automatic check_outputs(input string req);
    logic [SEGS-1:0] t;
    t = exp_taps(model);
    check(seg_tap == t, req, 64'(seg_tap), 64'(t));
    check(tail_q == model[TOTAL-1], "R4 tail_q", 64'(tail_q), 64'(model[TOTAL-1]));
    check(tail_qn == ~model[TOTAL-1], "R4 tail_qn", 64'(tail_qn), 64'(~model[TOTAL-1]));
  endtask

  task automatic run_shift(input logic st, input logic rc, input logic sb,
                           input logic a, input logic b, input bit keep_req);
    logic nb;
    @(negedge clk);
    shift_req = 1'b1; stagger = st; recirc = rc; sel_b = sb; din_a = a; din_b = b;
    nb = next_bit(rc, sb, a, b, model);
    @(negedge clk);
    if (!keep_req) shift_req = 1'b0;
    stagger = ~st;
    if (st) begin
      for (int i = 0; i < SEGS; i++) begin
        logic [SEGS-1:0] e;
        e = SEGS'(1) << (SEGS - 1 - i);
        check(seg_strobe == e, "R6 strobe walk", 64'(seg_strobe), 64'(e));
        check(done == 1'b0, "R6 done early", 64'(done), 64'(0));
        if (i != SEGS - 1) @(negedge clk);
      end
    end else begin
      check(seg_strobe == {SEGS{1'b1}}, "R5 all strobes", 64'(seg_strobe), 64'({SEGS{1'b1}}));
      check(done == 1'b0, "R5 done early", 64'(done), 64'(0));
    end
    @(negedge clk);
    shift_req = 1'b0;
    check(done == 1'b1, st ? "R6 done" : "R5 done", 64'(done), 64'(1));
    check(seg_strobe == '0, keep_req ? "R9 no restart" : "R5 strobes low", 64'(seg_strobe), 64'(0));
    model = {model[TOTAL-2:0], nb};
    check_outputs(rc ? "R7 recirculate" : (sb ? "R3 input B" : "R3 input A"));
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", 64'(done), 64'(0));
    check(seg_strobe == '0, "R9 idle after", 64'(seg_strobe), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1995));
    rst = 1'b1; shift_req = 1'b0; stagger = 1'b0; recirc = 1'b0;
    sel_b = 1'b0; din_a = 1'b0; din_b = 1'b0;
    model = '0;
    repeat (3) @(negedge clk);
    shift_req = 1'b1; din_a = 1'b1;
    @(negedge clk);
    check(seg_strobe == '0, "R1 strobe reset", 64'(seg_strobe), 64'(0));
    check(done == 1'b0, "R1 done reset", 64'(done), 64'(0));
    check_outputs("R1 taps reset");
    rst = 1'b0; shift_req = 1'b0;

    // directed: load pattern via A and B, both orderings (R2, R3)
    for (int i = 0; i < TOTAL; i++)
      run_shift(i[0], 1'b0, i[1], i[2] ^ i[5], ~(i[3] ^ i[0]), 1'b0);

    // directed: staggered recirculation with held request (R7, R9)
    for (int i = 0; i < 20; i++) run_shift(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // idle: inputs toggle with no request, contents stay (R8)
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      din_a = 1'($urandom); din_b = 1'($urandom); sel_b = 1'($urandom);
      recirc = 1'($urandom); stagger = 1'($urandom);
      check(seg_strobe == '0, "R8 no strobe", 64'(seg_strobe), 64'(0));
      check_outputs("R8 contents held");
    end

    // constrained random mix
    for (int i = 0; i < 300; i++)
      run_shift(1'($urandom), ($urandom % 10) < 3, 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule